// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between instruction fetch and decode in a core whose instructions are either one halfword (16 bits) or two halfwords (32 bits) long. Fetch hands it aligned 32-bit words through a valid/ready handshake. The block cuts that stream into whole instructions and presents at most one per cycle, with a flag that gives its length and the byte address where it starts. There is no padding in the stream, so a 32-bit instruction can begin in the upper halfword of one fetch word and end in the lower halfword of the next. The block holds leftover halfwords in a small queue to cover that case.

The length is read from bits [15:11] of the first halfword, before any real decode. The values 11101, 11110 and 11111 mark a 32-bit instruction. All other values mark a 16-bit one. When the core changes flow, it drives a redirect with a new target. The queue is emptied in that same cycle. If the target has bit 1 set, the lower halfword of the next accepted fetch word is dropped. No instruction comes out until fresh fetch data has arrived.

Top module: `instr_aligner`

## Requirements
- R1: While reset is held and just after it is released, `out_valid_o` is 0 and `fetch_ready_o` is 1.
- R2: An output instruction is 32-bit (`long_o`=1) exactly when its first halfword has bits [15:11] equal to 11101, 11110 or 11111. Any other value gives a 16-bit output.
- R3: A 16-bit instruction appears as `instr_o` = {16'h0000, halfword}. A 32-bit instruction appears as `instr_o` = {first halfword, second halfword}. The second halfword of a 32-bit instruction is never output as an instruction of its own.
- R4: When the queue holds only the first halfword of a 32-bit instruction, `out_valid_o` stays 0 until the next halfword has been accepted.
- R5: `addr_o` gives the start byte address of the output instruction. After each output it advances by 2 for a 16-bit instruction and by 4 for a 32-bit one.
- R6: In a cycle with `redirect_i`=1, `out_valid_o` and `fetch_ready_o` are both 0 and all buffered halfwords are discarded. `out_valid_o` stays 0 until a fetch word has been accepted after the redirect.
- R7: After a redirect, the first instruction has address `redirect_addr_i` with bit 0 cleared. If bit 1 of the target is set, the lower halfword of the first accepted fetch word is dropped and never output.
- R8: `fetch_ready_o` is 0 whenever more than BUF_HW-2 halfwords are buffered. Under back-pressure no halfword is lost or repeated.
- R9: Fetch words are little-endian. Bits [15:0] are the halfword at the lower address and are consumed before bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch word present |
| fetch_ready_o | output | 1 | Block accepts the fetch word this cycle |
| fetch_data_i | input | 32 | Fetch word, lower address halfword in [15:0] |
| redirect_i | input | 1 | Flow change; flush and restart at the target |
| redirect_addr_i | input | ADDR_W | Byte address of the new target |
| out_valid_o | output | 1 | A complete instruction is presented |
| instr_o | output | 32 | Instruction bits, layout per R3 |
| long_o | output | 1 | 1 for a 32-bit instruction |
| addr_o | output | ADDR_W | Start byte address of the instruction |

## Verification
The bench targets several corner cases.

- **Straddle:** a 32-bit instruction whose first halfword sits in the upper half of a fetch word, with the second word held back. A design that emits too early shows garbage in the low half, or issues the prefix as a 16-bit instruction.
- **Length boundary:** the prefixes 11100 and 11101. A decoder with an off-by-one compare classes these wrongly, and the rest of the stream falls out of step.
- **Odd-halfword targets:** a design that keeps the dropped lower halfword issues a stray instruction.
- **Back-pressure:** the queue is filled by a run of 16-bit instructions. A wrong ready threshold either overflows the queue or repeats data.

Long random runs with random redirects then compare every output against a stream decoded by the bench from its own memory model.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  typedef logic [15:0] hw_t;

  // 32-bit instruction when top five bits are 11101, 11110 or 11111
  function automatic logic hw_is_long(hw_t hw);
    return (hw[15:13] == 3'b111) && (hw[12:11] != 2'b00);
  endfunction

endpackage

// File: rtl/aligner_predecode.sv
module aligner_predecode
  import aligner_pkg::*;
(
  input  hw_t  hw_i,
  output logic long_o
);

  assign long_o = hw_is_long(hw_i);

endmodule

// File: rtl/aligner_hw_queue.sv
module aligner_hw_queue
  import aligner_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [1:0]       push_n_i,
  input  hw_t  [1:0]       push_hw_i,
  input  logic [1:0]       pop_n_i,
  output hw_t  [1:0]       head_o,
  output logic [CNT_W-1:0] cnt_o
);

  hw_t              q   [DEPTH];
  hw_t              nxt [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // shift-down queue: entry i takes entry i+pop, else incoming halfwords
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      int k;
      src = i + int'(pop_n_i);
      k   = src - int'(cnt_q);
      nxt[i] = q[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (j == src && j < int'(cnt_q)) nxt[i] = q[j];
      end
      if (k == 0 && push_n_i != 2'd0) nxt[i] = push_hw_i[0];
      if (k == 1 && push_n_i == 2'd2) nxt[i] = push_hw_i[1];
    end
  end

  always_comb begin
    if (flush_i) cnt_d = '0;
    else         cnt_d = cnt_q - CNT_W'(pop_n_i) + CNT_W'(push_n_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) q[i] <= nxt[i];
    end
  end

  assign head_o[0] = q[0];
  assign head_o[1] = q[1];
  assign cnt_o     = cnt_q;

endmodule

// File: rtl/instr_aligner.sv
module instr_aligner
  import aligner_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUF_HW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  output logic              fetch_ready_o,
  input  logic [31:0]       fetch_data_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] redirect_addr_i,
  output logic              out_valid_o,
  output logic [31:0]       instr_o,
  output logic              long_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int CNT_W = $clog2(BUF_HW + 1);
  localparam logic [CNT_W-1:0] READY_MAX = CNT_W'(BUF_HW - 2);

  logic [CNT_W-1:0]  buf_cnt;
  hw_t  [1:0]        head;
  hw_t  [1:0]        push_hw;
  logic [1:0]        push_n, pop_n;
  logic              head_long, accept;
  logic              skip_lo_q;
  logic [ADDR_W-1:0] pc_q;

  assign fetch_ready_o = !redirect_i && (buf_cnt <= READY_MAX);
  assign accept        = fetch_valid_i && fetch_ready_o;

  // odd-halfword target: drop lower half of first word
  assign push_hw[0] = skip_lo_q ? fetch_data_i[31:16] : fetch_data_i[15:0];
  assign push_hw[1] = fetch_data_i[31:16];
  assign push_n     = !accept ? 2'd0 : (skip_lo_q ? 2'd1 : 2'd2);

  aligner_predecode u_pre (
    .hw_i   (head[0]),
    .long_o (head_long)
  );

  assign out_valid_o = !redirect_i && (buf_cnt != '0) &&
                       (!head_long || buf_cnt >= CNT_W'(2));
  assign pop_n       = !out_valid_o ? 2'd0 : (head_long ? 2'd2 : 2'd1);
  assign instr_o     = head_long ? {head[0], head[1]} : {16'h0000, head[0]};
  assign long_o      = head_long;
  assign addr_o      = pc_q;

  aligner_hw_queue #(.DEPTH(BUF_HW)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (redirect_i),
    .push_n_i  (push_n),
    .push_hw_i (push_hw),
    .pop_n_i   (pop_n),
    .head_o    (head),
    .cnt_o     (buf_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= '0;
      skip_lo_q <= 1'b0;
    end else if (redirect_i) begin
      pc_q      <= {redirect_addr_i[ADDR_W-1:1], 1'b0};
      skip_lo_q <= redirect_addr_i[1];
    end else begin
      if (out_valid_o) pc_q <= pc_q + (head_long ? ADDR_W'(4) : ADDR_W'(2));
      if (accept)      skip_lo_q <= 1'b0;
    end
  end

endmodule

// File: rtl/aligner_chk.sv
module aligner_chk #(
  parameter int ADDR_W = 32,
  parameter int BUF_HW = 4,
  localparam int CNT_W = $clog2(BUF_HW + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              redirect_i,
  input logic [ADDR_W-1:0] redirect_addr_i,
  input logic              fetch_ready_o,
  input logic              out_valid_o,
  input logic [31:0]       instr_o,
  input logic              long_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  buf_cnt
);

  // R2
  len_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (long_o ? (instr_o[31:27] >= 5'b11101)
                            : (instr_o[15:11] < 5'b11101 && instr_o[31:16] == 16'h0000)));

  // R4
  whole_instr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (buf_cnt >= (long_o ? CNT_W'(2) : CNT_W'(1))));

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> addr_o == $past(addr_o) + ($past(long_o) ? ADDR_W'(4) : ADDR_W'(2)));

  // R6
  redirect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> (!out_valid_o && !fetch_ready_o));

  // R6
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> (buf_cnt == '0 && !out_valid_o));

  // R7
  target_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> addr_o == ($past(redirect_addr_i) & ~ADDR_W'(1)));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_cnt <= CNT_W'(BUF_HW));

  // R8
  ready_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ready_o |-> buf_cnt <= CNT_W'(BUF_HW - 2));

endmodule

bind instr_aligner aligner_chk #(.ADDR_W(ADDR_W), .BUF_HW(BUF_HW)) u_chk (.*);

// File: tb/sim_instr_aligner.sv
module sim_instr_aligner;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_valid_i = 1'b0;
  logic        fetch_ready_o;
  logic [31:0] fetch_data_i = '0;
  logic        redirect_i = 1'b0;
  logic [31:0] redirect_addr_i = '0;
  logic        out_valid_o;
  logic [31:0] instr_o;
  logic        long_o;
  logic [31:0] addr_o;

  int checks = 0;
  int errors = 0;
  logic s_v, s_rdy, s_long;
  logic [31:0] s_instr, s_addr;

  always #4 clk_i = ~clk_i;

  instr_aligner u0 (.*);

  function automatic logic is_long(logic [15:0] hw);
    return hw[15:11] == 5'd29 || hw[15:11] == 5'd30 || hw[15:11] == 5'd31;
  endfunction

  function automatic logic [15:0] mem_hw(logic [31:0] a);
    logic [31:0] h;
    logic [15:0] v;
    h = (a ^ 32'h5A5A1234) * 32'h9E3779B1;
    h = h ^ (h >> 15);
    v = h[31:16];
    if (h[3:0] < 4'd5) begin
      case (h[5:4])
        2'd0:    v[15:11] = 5'b11101;
        2'd1:    v[15:11] = 5'b11110;
        default: v[15:11] = 5'b11111;
      endcase
    end else if (v[15:11] >= 5'd29) begin
      v[15:11] = v[15:11] - 5'd8;
    end
    return v;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample after settling, then let the edge commit
  task automatic step(input logic v, input logic [31:0] d, input logic r, input logic [31:0] a);
    @(negedge clk_i);
    fetch_valid_i = v; fetch_data_i = d; redirect_i = r; redirect_addr_i = a;
    #1;
    s_v = out_valid_o; s_rdy = fetch_ready_o; s_long = long_o;
    s_instr = instr_o; s_addr = addr_o;
  endtask

  task automatic idle();
    step(1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic exp_out(input logic [31:0] ins, input logic lg, input logic [31:0] ad, input string tag);
    chk(s_v == 1'b1, tag, {63'h0, s_v}, 64'h1);
    chk(s_instr == ins && s_long == lg && s_addr == ad, tag,
        {s_addr, s_instr}, {ad, ins});
  endtask

  task automatic exp_none(input string tag);
    chk(s_v == 1'b0, tag, {63'h0, s_v}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act hung exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] fptr, exp_pc, tgt;
    logic [15:0] eh;
    logic el, acc, rd, vl;
    int seed_dummy;
    seed_dummy = $urandom(32'd20240607);

    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    chk(!out_valid_o && fetch_ready_o, "R1 in reset", {62'h0, out_valid_o, fetch_ready_o}, 64'h1);
    rst_ni = 1'b1;
    idle();
    chk(!s_v && s_rdy, "R1 after reset", {62'h0, s_v, s_rdy}, 64'h1);

    // odd-halfword target drops lower half (R7)
    step(1'b0, 32'h0, 1'b1, 32'h0000_0102);
    chk(!s_v && !s_rdy, "R6 redirect cycle", {62'h0, s_v, s_rdy}, 64'h0);
    step(1'b1, 32'h1234_F000, 1'b0, 32'h0);
    exp_none("R6 no output before data");
    idle(); exp_out(32'h0000_1234, 1'b0, 32'h102, "R7 first after odd target");
    idle(); exp_none("R7 dropped lower half not issued");

    // straddle across fetch words (R4, R3, R9)
    step(1'b0, 32'h0, 1'b1, 32'h0000_0200);
    step(1'b1, 32'hF0AA_4455, 1'b0, 32'h0);
    idle(); exp_out(32'h0000_4455, 1'b0, 32'h200, "R9 lower halfword first");
    idle(); exp_none("R4 stall on lone prefix");
    step(1'b1, 32'h2222_B0BB, 1'b0, 32'h0);
    exp_none("R4 stall until second half accepted");
    idle(); exp_out(32'hF0AA_B0BB, 1'b1, 32'h202, "R3 straddled 32-bit layout");
    idle(); exp_out(32'h0000_2222, 1'b0, 32'h206, "R5 advance by 4");
    idle(); exp_none("R3 queue drained");

    // length code boundary (R2)
    step(1'b0, 32'h0, 1'b1, 32'h0000_0300);
    step(1'b1, 32'hE800_E7FF, 1'b0, 32'h0);
    step(1'b1, 32'h0001_1234, 1'b0, 32'h0);
    exp_out(32'h0000_E7FF, 1'b0, 32'h300, "R2 prefix 11100 short");
    idle(); exp_out(32'hE800_1234, 1'b1, 32'h302, "R2 prefix 11101 long");
    idle(); exp_out(32'h0000_0001, 1'b0, 32'h306, "R5 after long");

    // back-pressure with short instructions (R8)
    step(1'b0, 32'h0, 1'b1, 32'h0000_0400);
    step(1'b1, 32'h0002_0001, 1'b0, 32'h0);
    step(1'b1, 32'h0004_0003, 1'b0, 32'h0);
    exp_out(32'h1, 1'b0, 32'h400, "R8 fill a");
    chk(s_rdy, "R8 ready with room", {63'h0, s_rdy}, 64'h1);
    step(1'b1, 32'h0006_0005, 1'b0, 32'h0);
    chk(!s_rdy, "R8 ready low when full", {63'h0, s_rdy}, 64'h0);
    exp_out(32'h2, 1'b0, 32'h402, "R8 fill b");
    step(1'b1, 32'h0006_0005, 1'b0, 32'h0);
    exp_out(32'h3, 1'b0, 32'h404, "R8 fill c");
    idle(); exp_out(32'h4, 1'b0, 32'h406, "R8 no loss d");
    idle(); exp_out(32'h5, 1'b0, 32'h408, "R8 no loss e");
    idle(); exp_out(32'h6, 1'b0, 32'h40A, "R8 no loss f");
    idle(); exp_none("R8 no repeat");

    // random stream against bench memory model
    tgt = 32'h0000_0800;
    step(1'b0, 32'h0, 1'b1, tgt);
    fptr = tgt & ~32'h3; exp_pc = tgt & ~32'h1;
    for (int c = 0; c < 4000; c++) begin
      rd  = ($urandom % 40) == 0;
      vl  = ($urandom % 10) < 7;
      tgt = $urandom & 32'h0000_3FFE;
      step(vl, {mem_hw(fptr + 32'd2), mem_hw(fptr)}, rd, tgt);
      acc = vl && s_rdy;
      if (rd) begin
        chk(!s_v && !s_rdy, "R6 random redirect", {62'h0, s_v, s_rdy}, 64'h0);
      end else if (s_v) begin
        eh = mem_hw(exp_pc);
        el = is_long(eh);
        exp_out(el ? {eh, mem_hw(exp_pc + 32'd2)} : {16'h0, eh}, el, exp_pc, "R3 random stream");
        exp_pc = exp_pc + (el ? 32'd4 : 32'd2);
      end
      if (acc) fptr = fptr + 32'd4;
      if (rd) begin
        fptr = tgt & ~32'h3;
        exp_pc = tgt & ~32'h1;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule